// File: doc/BRIEF.md
# Cluster Performance Counter Unit

This block gives software a way to count hardware events. It has a configurable set of 32-bit event counters and one 64-bit cycle counter. Each event counter is given an event code that picks one line of the `evt_in` pulse vector. The counter adds one on every clock in which that line is high. Two codes have a fixed meaning. The cycles code is never served by an event counter. The chain code makes a counter count the wraps of the counter just below it, so that two 32-bit counters act as one 64-bit count.

All access goes through a flat register port with a single-cycle write strobe and a combinational read. The port covers:
- a control word that holds the global run bit, two self-clearing zeroing commands, the counter count and fixed identification fields;
- set and clear masks for counting and for interrupts;
- an overflow status register with two access points: write-1-to-clear, and read-and-reset;
- a select/type/value window onto one event counter;
- the two halves of the cycle counter;
- two words that report which common event codes are supported.

The level-sensitive `irq` output stays high while any overflow bit is set whose interrupt enable is also set.

In every counter bitmap, bit i stands for event counter i and bit 31 stands for the cycle counter.

Top module: `pmu_cluster_top`

## Requirements
- R1: Address 0x0 (control) reads back as follows: bit 0 is the run flag that was last written; bits 2:1 read 0; bits 15:11 hold NUM_CNT; bits 23:16 hold ID_CODE; bits 31:24 hold IMP_CODE. Writes to bits 31:3 have no effect.
- R2: An event counter i adds 1 at a clock edge only when all of the following are true: the run flag is set, enable bit i is set, and its code is below 64 and selects an `evt_in` line that is high. A code of 64 or more never counts. A disabled counter holds its value.
- R3: The 64-bit cycle counter adds 1 at each edge while the run flag and enable bit 31 are both set. Its halves are read and written at 0xA (low) and 0xB (high). A write to either half replaces that half, holds the other half, and suppresses the increment for that cycle. A wrap from all ones to zero sets overflow bit 31.
- R4: An event counter with code 0x11 (cycles) never counts.
- R5: A counter i>0 with code 0x1E (chain) adds 1 at each edge where counter i-1 wraps.
- R6: An event counter that wraps from 0xFFFFFFFF to 0 becomes 0 and sets its overflow bit.
- R7: Enable masks are written through set registers (0x1 for counting, 0x3 for interrupts) and clear registers (0x2 for counting, 0x4 for interrupts). A write changes only the bits given as 1. Either address of a pair reads the current mask. Bits of counters that are not implemented always read 0.
- R8: `irq` is high exactly when some overflow bit and its interrupt-enable bit are both set.
- R9: A write to 0x5 clears the overflow bits given as 1. A read at 0x5 has no side effect. A read at 0x6 (read strobe high) returns the status and clears the bits it returned. An overflow that occurs in that same cycle stays set.
- R10: A write to 0x9 loads the selected event counter. The write takes priority over an increment in the same cycle, and counting continues from the written value.
- R11: A control write with bit 1 set zeroes all event counters. A control write with bit 2 set zeroes the cycle counter. Each takes priority over any increment or value write in that cycle.
- R12: 0xC and 0xD return bits 31:0 and 63:32 of the CEID parameter.
- R13: Register 0x7 selects a counter. 0x8 is the selected counter's event code in bits 7:0, and 0x9 is its value. When the select is NUM_CNT or more, 0x8 and 0x9 read 0 and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | NUM_IN | Event pulse lines, one per event code |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Read strobe (matters only for read-and-reset) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq | output | 1 | Level overflow interrupt |

## Verification
Two things can collide in one cycle. The first is a read-and-reset of the overflow status while a counter is wrapping. The bench provokes this by loading counter 4 with all ones and, in the same cycle, raising its event line and reading 0x6. It then judges that the old bit was returned and cleared while the new bit survived. The second collision is a value write landing on a cycle with an event pulse; here the written value must win. A behavioural model, updated every clock, judges the read data and `irq` on every cycle as well.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int SEL_W   = 5;
    localparam int CODE_W  = 8;
    localparam int CYC_BIT = 31;

    localparam logic [CODE_W-1:0] EVC_CYCLES = 8'h11;
    localparam logic [CODE_W-1:0] EVC_CHAIN  = 8'h1E;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL    = 4'h0,
        RA_EN_SET  = 4'h1,
        RA_EN_CLR  = 4'h2,
        RA_IE_SET  = 4'h3,
        RA_IE_CLR  = 4'h4,
        RA_OVF     = 4'h5,
        RA_OVF_RR  = 4'h6,
        RA_SEL     = 4'h7,
        RA_EVTYPE  = 4'h8,
        RA_EVCNT   = 4'h9,
        RA_CYC_LO  = 4'hA,
        RA_CYC_HI  = 4'hB,
        RA_CEID_LO = 4'hC,
        RA_CEID_HI = 4'hD
    } reg_sel_e;

    typedef struct packed {
        logic run_wr;
        logic run_val;
        logic zero_evt;
        logic zero_cyc;
    } ctrl_cmd_t;

    // Bitmap of implemented counters: event counters 0..n-1 plus the cycle bit.
    function automatic logic [DATA_W-1:0] impl_mask(int n);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < CYC_BIT; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        m[CYC_BIT] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/pmu_evt_ctr.sv
module pmu_evt_ctr
    import pmu_pkg::*;
#(
    parameter int NUM_IN = 64,
    parameter int CW     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              count_ok,
    input  logic [NUM_IN-1:0] evt_in,
    input  logic              chain_in,
    input  logic              clr,
    input  logic              val_wr,
    input  logic [CW-1:0]     val_wdata,
    input  logic              code_wr,
    input  logic [CODE_W-1:0] code_wdata,
    output logic [CW-1:0]     value,
    output logic [CODE_W-1:0] code,
    output logic              wrap
);
    localparam int IW = $clog2(NUM_IN);

    logic hit;
    logic inc;

    always_comb begin
        hit = 1'b0;
        if (code == EVC_CHAIN)
            hit = chain_in;
        else if (code != EVC_CYCLES && int'(code) < NUM_IN)
            hit = evt_in[code[IW-1:0]];
    end

    assign inc  = count_ok & hit;
    assign wrap = inc & (&value) & ~val_wr & ~clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
            code  <= '0;
        end else begin
            if (code_wr) code <= code_wdata;
            if (clr)
                value <= '0;
            else if (val_wr)
                value <= val_wdata;
            else if (inc)
                value <= value + 1'b1;
        end
    end

    AST_EVT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!count_ok && !val_wr && !clr) |=> $stable(value)); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (value == '0)); // R6
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr |=> (value == '0)); // R11
endmodule

// File: rtl/pmu_cyc_ctr.sv
module pmu_cyc_ctr #(
    parameter int CW = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            count_ok,
    input  logic            clr,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [CW/2-1:0] wdata,
    output logic [CW-1:0]   value,
    output logic            wrap
);
    localparam int HW = CW / 2;

    logic any_wr;
    assign any_wr = wr_lo | wr_hi;
    assign wrap   = count_ok & (&value) & ~any_wr & ~clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else if (any_wr) begin
            if (wr_lo) value[HW-1:0]  <= wdata;
            if (wr_hi) value[CW-1:HW] <= wdata;
        end else if (count_ok) begin
            value <= value + 1'b1;
        end
    end

    AST_CYC_STEP: assert property (@(posedge clk) disable iff (rst)
        (count_ok && !clr && !any_wr) |=> (value == $past(value) + 1'b1)); // R3
    AST_CYC_HALF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && !wr_hi && !clr) |=> (value[CW-1:HW] == $past(value[CW-1:HW]))); // R3
endmodule

// File: rtl/pmu_cluster_top.sv
module pmu_cluster_top
    import pmu_pkg::*;
#(
    parameter int          NUM_CNT  = 6,
    parameter int          NUM_IN   = 64,
    parameter logic [7:0]  ID_CODE  = 8'h3C,
    parameter logic [7:0]  IMP_CODE = 8'h7E,
    parameter logic [63:0] CEID     = 64'h0000_0003_7E60_2A11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] evt_in,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    localparam logic [DATA_W-1:0] IMPL = impl_mask(NUM_CNT);
    localparam int                HALF = DATA_W;

    reg_sel_e          ra;
    ctrl_cmd_t         cmd;
    logic              glb_en;
    logic [DATA_W-1:0] cnt_en, int_en, ovs;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] wrap_vec, ovs_clr;

    logic [DATA_W-1:0] cnt_val  [NUM_CNT];
    logic [CODE_W-1:0] cnt_code [NUM_CNT];
    logic [NUM_CNT-1:0] evt_wrap;
    logic [NUM_CNT-1:0] chain_vec;
    logic [2*HALF-1:0] cyc_val;
    logic              cyc_wrap;

    assign ra = reg_sel_e'(reg_addr);

    always_comb begin
        cmd.run_wr   = reg_we && ra == RA_CTRL;
        cmd.run_val  = reg_wdata[0];
        cmd.zero_evt = cmd.run_wr && reg_wdata[1];
        cmd.zero_cyc = cmd.run_wr && reg_wdata[2];
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CNT; gi++) begin : g_evt
            if (gi == 0) begin : g_head
                assign chain_vec[gi] = 1'b0;
            end else begin : g_link
                assign chain_vec[gi] = evt_wrap[gi-1];
            end
            pmu_evt_ctr #(.NUM_IN(NUM_IN), .CW(DATA_W)) u_ctr (
                .clk        (clk),
                .rst        (rst),
                .count_ok   (glb_en & cnt_en[gi]),
                .evt_in     (evt_in),
                .chain_in   (chain_vec[gi]),
                .clr        (cmd.zero_evt),
                .val_wr     (reg_we && ra == RA_EVCNT && int'(sel) == gi),
                .val_wdata  (reg_wdata),
                .code_wr    (reg_we && ra == RA_EVTYPE && int'(sel) == gi),
                .code_wdata (reg_wdata[CODE_W-1:0]),
                .value      (cnt_val[gi]),
                .code       (cnt_code[gi]),
                .wrap       (evt_wrap[gi])
            );
        end
    endgenerate

    pmu_cyc_ctr #(.CW(2*HALF)) u_cyc (
        .clk      (clk),
        .rst      (rst),
        .count_ok (glb_en & cnt_en[CYC_BIT]),
        .clr      (cmd.zero_cyc),
        .wr_lo    (reg_we && ra == RA_CYC_LO),
        .wr_hi    (reg_we && ra == RA_CYC_HI),
        .wdata    (reg_wdata),
        .value    (cyc_val),
        .wrap     (cyc_wrap)
    );

    always_comb begin
        wrap_vec = '0;
        for (int i = 0; i < NUM_CNT; i++) wrap_vec[i] = evt_wrap[i];
        wrap_vec[CYC_BIT] = cyc_wrap;
        ovs_clr = '0;
        if (reg_we && ra == RA_OVF)    ovs_clr = ovs_clr | reg_wdata;
        if (reg_re && ra == RA_OVF_RR) ovs_clr = ovs_clr | ovs;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            glb_en <= 1'b0;
            cnt_en <= '0;
            int_en <= '0;
            ovs    <= '0;
            sel    <= '0;
        end else begin
            if (cmd.run_wr) glb_en <= cmd.run_val;
            if (reg_we && ra == RA_EN_SET) cnt_en <= (cnt_en | reg_wdata) & IMPL;
            if (reg_we && ra == RA_EN_CLR) cnt_en <= cnt_en & ~reg_wdata;
            if (reg_we && ra == RA_IE_SET) int_en <= (int_en | reg_wdata) & IMPL;
            if (reg_we && ra == RA_IE_CLR) int_en <= int_en & ~reg_wdata;
            if (reg_we && ra == RA_SEL)    sel    <= reg_wdata[SEL_W-1:0];
            ovs <= ((ovs & ~ovs_clr) | wrap_vec) & IMPL;
        end
    end

    assign irq = |(ovs & int_en);

    always_comb begin
        reg_rdata = '0;
        unique case (ra)
            RA_CTRL:    reg_rdata = {IMP_CODE, ID_CODE, 5'(NUM_CNT), 8'b0, 2'b0, glb_en};
            RA_EN_SET,
            RA_EN_CLR:  reg_rdata = cnt_en;
            RA_IE_SET,
            RA_IE_CLR:  reg_rdata = int_en;
            RA_OVF,
            RA_OVF_RR:  reg_rdata = ovs;
            RA_SEL:     reg_rdata = {{(DATA_W-SEL_W){1'b0}}, sel};
            RA_EVTYPE: begin
                for (int i = 0; i < NUM_CNT; i++)
                    if (int'(sel) == i) reg_rdata = {{(DATA_W-CODE_W){1'b0}}, cnt_code[i]};
            end
            RA_EVCNT: begin
                for (int i = 0; i < NUM_CNT; i++)
                    if (int'(sel) == i) reg_rdata = cnt_val[i];
            end
            RA_CYC_LO:  reg_rdata = cyc_val[HALF-1:0];
            RA_CYC_HI:  reg_rdata = cyc_val[2*HALF-1:HALF];
            RA_CEID_LO: reg_rdata = CEID[31:0];
            RA_CEID_HI: reg_rdata = CEID[63:32];
            default:    reg_rdata = '0;
        endcase
    end

    AST_OVF_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!(reg_we && reg_addr == RA_OVF) && !(reg_re && reg_addr == RA_OVF_RR))
        |=> ((ovs & $past(ovs)) == $past(ovs))); // R9
    AST_EN_SET: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == RA_EN_SET)
        |=> ((cnt_en & $past(reg_wdata) & IMPL) == ($past(reg_wdata) & IMPL))); // R7
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (int_en == '0) |-> !irq); // R8
    AST_RR_RETURNED_GONE: assert property (@(posedge clk) disable iff (rst)
        (reg_re && reg_addr == RA_OVF_RR && wrap_vec == '0) |=> ((ovs & $past(ovs)) == '0)); // R9
endmodule

// File: tb/pmu_cluster_top_bench.sv
module pmu_cluster_top_bench;
    localparam int          PER      = 10;
    localparam int          N        = 6;
    localparam int          NIN      = 64;
    localparam logic [7:0]  IDC      = 8'h3C;
    localparam logic [7:0]  IMPC     = 8'h7E;
    localparam logic [63:0] CEIDV    = 64'h0000_0003_7E60_2A11;
    localparam logic [31:0] CTRL_RO  = {IMPC, IDC, 5'(N), 11'b0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NIN-1:0] evt_in = '0;
    logic reg_we = 1'b0, reg_re = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic irq;

    int compared = 0;
    int failed   = 0;
    string cur_tag = "R1";
    logic [31:0] rs = 32'h1234_5678;

    // reference model state
    logic        m_run;
    logic [31:0] m_en, m_ie, m_ovs, impl;
    logic [4:0]  m_sel;
    logic [7:0]  m_code [32];
    logic [31:0] m_cnt  [32];
    logic [63:0] m_cyc;

    pmu_cluster_top #(.NUM_CNT(N), .NUM_IN(NIN), .ID_CODE(IDC), .IMP_CODE(IMPC), .CEID(CEIDV))
    u_pmu_cluster_top (
        .clk(clk), .rst(rst), .evt_in(evt_in), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #(PER/2) clk = ~clk;

    function automatic logic [31:0] model_rd(logic [3:0] a);
        case (a)
            4'h0: return CTRL_RO | {31'b0, m_run};
            4'h1, 4'h2: return m_en;
            4'h3, 4'h4: return m_ie;
            4'h5, 4'h6: return m_ovs;
            4'h7: return {27'b0, m_sel};
            4'h8: return (int'(m_sel) < N) ? {24'b0, m_code[m_sel]} : 32'h0;
            4'h9: return (int'(m_sel) < N) ? m_cnt[m_sel] : 32'h0;
            4'hA: return m_cyc[31:0];
            4'hB: return m_cyc[63:32];
            4'hC: return CEIDV[31:0];
            4'hD: return CEIDV[63:32];
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        compared++;
        if (got !== exp) begin
            failed++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_update();
        logic zero_e, zero_c, prev_w, ok, hit, inc, vw, w, lo_w, hi_w;
        logic [31:0] clr_m, new_ovs, wd;
        logic [3:0] a;
        if (rst) begin
            m_run = 0; m_en = 0; m_ie = 0; m_ovs = 0; m_sel = 0; m_cyc = 0;
            for (int i = 0; i < 32; i++) begin m_code[i] = 0; m_cnt[i] = 0; end
            return;
        end
        a = reg_addr; wd = reg_wdata;
        zero_e = reg_we && a == 4'h0 && wd[1];
        zero_c = reg_we && a == 4'h0 && wd[2];
        clr_m = 0;
        if (reg_we && a == 4'h5) clr_m = clr_m | wd;
        if (reg_re && a == 4'h6) clr_m = clr_m | m_ovs;
        new_ovs = 0; prev_w = 0;
        for (int i = 0; i < N; i++) begin
            ok = m_run && m_en[i];
            if (m_code[i] == 8'h1E) hit = prev_w;
            else if (m_code[i] != 8'h11 && m_code[i] < 64) hit = evt_in[m_code[i]];
            else hit = 0;
            inc = ok && hit;
            vw = reg_we && a == 4'h9 && int'(m_sel) == i;
            w = inc && m_cnt[i] == 32'hFFFF_FFFF && !vw && !zero_e;
            if (zero_e) m_cnt[i] = 0;
            else if (vw) m_cnt[i] = wd;
            else if (inc) m_cnt[i] = m_cnt[i] + 1;
            new_ovs[i] = w; prev_w = w;
            if (reg_we && a == 4'h8 && int'(m_sel) == i) m_code[i] = wd[7:0];
        end
        ok = m_run && m_en[31];
        lo_w = reg_we && a == 4'hA; hi_w = reg_we && a == 4'hB;
        w = ok && m_cyc == 64'hFFFF_FFFF_FFFF_FFFF && !lo_w && !hi_w && !zero_c;
        if (zero_c) m_cyc = 0;
        else if (lo_w || hi_w) begin
            if (lo_w) m_cyc[31:0] = wd;
            if (hi_w) m_cyc[63:32] = wd;
        end else if (ok) m_cyc = m_cyc + 1;
        new_ovs[31] = w;
        m_ovs = ((m_ovs & ~clr_m) | new_ovs) & impl;
        if (reg_we && a == 4'h0) m_run = wd[0];
        if (reg_we && a == 4'h1) m_en = (m_en | wd) & impl;
        if (reg_we && a == 4'h2) m_en = m_en & ~wd;
        if (reg_we && a == 4'h3) m_ie = (m_ie | wd) & impl;
        if (reg_we && a == 4'h4) m_ie = m_ie & ~wd;
        if (reg_we && a == 4'h7) m_sel = wd[4:0];
    endtask

    // called just after a falling edge with inputs already driven
    task automatic step();
        #2;
        if (!rst) begin
            check(cur_tag, reg_rdata, model_rd(reg_addr));
            check(cur_tag, {31'b0, irq}, {31'b0, |(m_ovs & m_ie)});
        end
        model_update();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 0; reg_wdata = 0;
    endtask

    task automatic expect_rd(string tag, logic [3:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
        step();
    endtask

    task automatic expect_irq(string tag, logic exp);
        #1;
        check(tag, {31'b0, irq}, {31'b0, exp});
        step();
    endtask

    initial begin
        #(PER * 200000);
        failed++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, failed);
        $finish;
    end

    initial begin
        impl = 32'h8000_0000;
        for (int i = 0; i < N; i++) impl[i] = 1'b1;
        @(negedge clk);
        repeat (3) step();
        rst = 0;

        cur_tag = "R1";
        expect_rd("R1", 4'h0, CTRL_RO);
        wr(4'h0, 32'hFFFF_FFF9);
        expect_rd("R1", 4'h0, CTRL_RO | 32'h1);

        cur_tag = "R7";
        wr(4'h1, 32'h8000_0C3F);
        expect_rd("R7", 4'h1, 32'h8000_003F);
        wr(4'h2, 32'h0000_0020);
        expect_rd("R7", 4'h2, 32'h8000_001F);
        wr(4'h3, 32'h0000_0400);
        expect_rd("R7", 4'h3, 32'h0);

        cur_tag = "R2";
        wr(4'h7, 0); wr(4'h8, 8'h03);
        wr(4'h7, 1); wr(4'h8, 8'h1E);
        wr(4'h7, 2); wr(4'h8, 8'h11);
        wr(4'h7, 3); wr(4'h8, 8'h50);
        wr(4'h7, 4); wr(4'h8, 8'h07);
        for (int k = 0; k < 40; k++) begin
            rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
            evt_in = {rs, ~rs};
            reg_addr = 4'(k % 14);
            step();
        end
        evt_in = '0;
        for (int i = 0; i < N; i++) begin
            wr(4'h7, 32'(i));
            expect_rd("R2", 4'h9, m_cnt[i]);
        end
        wr(4'h7, 2); expect_rd("R4", 4'h9, 32'h0);
        wr(4'h7, 3); expect_rd("R2", 4'h9, 32'h0);
        wr(4'h7, 5); expect_rd("R2", 4'h9, 32'h0);

        cur_tag = "R10";
        wr(4'h7, 0);
        evt_in = 64'h8;
        wr(4'h9, 32'h7FFF_FFFF);
        expect_rd("R10", 4'h9, 32'h7FFF_FFFF);
        expect_rd("R10", 4'h9, 32'h8000_0000);
        evt_in = '0;

        cur_tag = "R6";
        wr(4'h9, 32'hFFFF_FFFE);
        evt_in = 64'h8; step(); step(); evt_in = '0;
        expect_rd("R6", 4'h9, 32'h0);
        expect_rd("R6", 4'h5, 32'h1);
        wr(4'h7, 1);
        expect_rd("R5", 4'h9, 32'h1);

        cur_tag = "R8";
        expect_irq("R8", 1'b0);
        wr(4'h3, 32'h1);
        expect_irq("R8", 1'b1);
        wr(4'h4, 32'h1);
        expect_irq("R8", 1'b0);

        cur_tag = "R9";
        wr(4'h5, 32'h0);
        expect_rd("R9", 4'h5, 32'h1);
        wr(4'h7, 4);
        wr(4'h9, 32'hFFFF_FFFF);
        evt_in = 64'h80; reg_re = 1; reg_addr = 4'h6;
        #1; check("R9", reg_rdata, 32'h1);
        step();
        reg_re = 0; evt_in = '0;
        expect_rd("R9", 4'h5, 32'h10);
        reg_re = 1;
        expect_rd("R9", 4'h5, 32'h10);
        reg_re = 0;
        expect_rd("R9", 4'h5, 32'h10);
        wr(4'h5, 32'h10);
        expect_rd("R9", 4'h5, 32'h0);

        cur_tag = "R3";
        wr(4'hB, 32'hFFFF_FFFF);
        wr(4'hA, 32'hFFFF_FFFF);
        step();
        expect_rd("R3", 4'hA, 32'h0);
        expect_rd("R3", 4'hB, 32'h0);
        expect_rd("R3", 4'h5, 32'h8000_0000);

        cur_tag = "R11";
        wr(4'h0, 32'h7);
        expect_rd("R11", 4'hA, 32'h0);
        expect_rd("R11", 4'hB, 32'h0);
        expect_rd("R11", 4'h9, 32'h0);
        wr(4'h7, 1);
        expect_rd("R11", 4'h9, 32'h0);

        cur_tag = "R12";
        expect_rd("R12", 4'hC, CEIDV[31:0]);
        expect_rd("R12", 4'hD, CEIDV[63:32]);

        cur_tag = "R13";
        wr(4'h7, 20);
        wr(4'h9, 32'h1234);
        wr(4'h8, 32'h07);
        expect_rd("R13", 4'h9, 32'h0);
        expect_rd("R13", 4'h8, 32'h0);
        wr(4'h7, 4);
        expect_rd("R13", 4'h9, 32'h0);
        expect_rd("R13", 4'h8, 32'h7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, failed);
        $finish;
    end
endmodule